// File: doc/BRIEF.md
# Descriptor chain sequencer with enable, suspend and chain resume

This block holds the 32-bit control word of one channel of a descriptor-chained DMA engine and runs the small state machine that sequences it. The channel fetches a descriptor, runs the transfer the descriptor describes, and then either moves to the next descriptor, re-reads the current one, or goes idle. Software talks to it through a simple register bus. Address 0 is the control word. Address 1 is the current-descriptor address. Address 2 is the next-descriptor address, which is read-only. The datapath is a stub outside this block: it answers a fetch request with a fetch-done pulse carrying the descriptor's next address, and it ends a transfer with a transfer-done pulse.

Clearing the enable bit freezes the channel where it stands. No new fetch or transfer beat is requested while it is clear, and setting it again continues the interrupted work. The chain-resume bit lets software extend a chain after the channel has reached its last descriptor. Setting it makes the channel read the current descriptor again, so that a next-address field patched in memory is picked up. Hardware clears the bit once that re-read has loaded the next address, or when a transfer finishes and the chain advances.

A 4-bit field of the control word forms the top address bits of every descriptor fetch, which keeps a whole chain inside one 4 GB window. A second 4-bit field, the endian orientation bit and the interface-select bit are only stored and driven out to the surrounding logic.

Top module: `dma_chain_ctl`

## Requirements
- R1: After reset, control word bits 31:30, 28:0 read 0, bit 29 reads the value of `strap_if_sel`, `active` is 0, and `fetch_req` and `xfer_run` are 0.
- R2: The channel is idle. A write to address 0 sets bit 0 (enable) and bit 1 (chain resume). Then `fetch_req` is 0 right after that write's clock edge and 1 one clock later. `fetch_addr` is {bits 23:20, current-descriptor address}.
- R3: A fetch-done that ends a re-read does three things. It loads `fetch_next` into the next-descriptor register (read at address 2), it clears bit 1, and it raises `xfer_run` from the following cycle.
- R4: A transfer-done with a non-zero next address does three things. It clears bit 1, it copies the next address into the current-descriptor register, and it requests the next fetch on the following cycle at {bits 23:20, that address}.
- R5: A transfer-done with a zero next address while bit 1 is set re-issues a fetch at the unchanged current-descriptor address on the following cycle.
- R6: A transfer-done with a zero next address while bit 1 is clear sends the channel idle. `active` falls and the current-descriptor address is kept.
- R7: While bit 0 is clear, `fetch_req` and `xfer_run` are 0 and `active` does not change. Setting bit 0 again during a transfer raises `xfer_run` with no new fetch.
- R8: While the channel is idle with bit 0 clear, a set bit 1 starts no fetch. `active` and `fetch_req` stay 0.
- R9: Reading address 0 returns 0 in bits 18:2. All other bits read back as last written, except that bit 1 is subject to hardware clearing. `crc_addr_hi` drives bits 27:24, `endian_sel` drives bit 19 and `if_sel` drives bit 29.
- R10: A write to address 1 updates the current-descriptor address only while the channel is idle. While the channel is active, the write has no effect on the value read back.
- R11: The control word can be rewritten while the channel is active. A new bits 23:20 value is used by the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_if_sel | input | 1 | Reset value of the interface-select bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 current descriptor, 2 next descriptor |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | 36 | Descriptor fetch address |
| fetch_done | input | 1 | Fetch complete pulse |
| fetch_next | input | 32 | Next-descriptor address of the fetched descriptor |
| xfer_run | output | 1 | Transfer may issue bus transactions |
| xfer_done | input | 1 | Transfer complete pulse |
| active | output | 1 | Channel busy with a chain |
| endian_sel | output | 1 | Stored endian orientation bit |
| if_sel | output | 1 | Stored interface-select bit |
| crc_addr_hi | output | 4 | Upper bits of the CRC result address |

## Verification
The properties assume that the stub datapath pulses fetch-done only while a fetch is requested and transfer-done only while a transfer runs. They also assume that software never clears enable or writes chain resume on the same cycle as one of those pulses, since the hardware clear would otherwise race the write. The stimulus follows these assumptions by construction. Every handshake pulse is issued at a moment the bench has computed, and suspend and resume writes fall only between pulses, with random chain lengths, random addresses, random window bits and random suspend lengths.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER} chain_state_e;

   // control word bit positions
   localparam int unsigned B_EN      = 0;
   localparam int unsigned B_CR      = 1;
   localparam int unsigned B_ENDIAN  = 19;
   localparam int unsigned F_DHI_LSB = 20;
   localparam int unsigned F_CHI_LSB = 24;
   localparam int unsigned B_KEEP0   = 28;
   localparam int unsigned B_IFSEL   = 29;
   localparam int unsigned B_KEEP1   = 30;
   localparam int unsigned B_KEEP2   = 31;
   localparam int unsigned HI_W      = 4;
   localparam int unsigned RSV_W     = 17;

   localparam logic [1:0] RA_CTL = 2'd0;
   localparam logic [1:0] RA_CUR = 2'd1;
   localparam logic [1:0] RA_NXT = 2'd2;
endpackage

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
   import dma_chain_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strap,
   input  logic            wr,
   input  logic [31:0]     wdata,
   input  logic            cr_clr,
   output logic [31:0]     word,
   output logic            en,
   output logic            cr,
   output logic            endian,
   output logic            ifsel,
   output logic [HI_W-1:0] dhi,
   output logic [HI_W-1:0] chi
);
   logic [2:0] keep_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b0;
         endian <= 1'b0;
         ifsel  <= strap;
         dhi    <= '0;
         chi    <= '0;
         keep_q <= '0;
      end else if (wr) begin
         en     <= wdata[B_EN];
         endian <= wdata[B_ENDIAN];
         ifsel  <= wdata[B_IFSEL];
         dhi    <= wdata[F_DHI_LSB +: HI_W];
         chi    <= wdata[F_CHI_LSB +: HI_W];
         keep_q <= {wdata[B_KEEP2], wdata[B_KEEP1], wdata[B_KEEP0]};
      end
   end

   // hardware clear takes priority over a same-cycle software write
   always_ff @(posedge clk) begin
      if (!rst_n)      cr <= 1'b0;
      else if (cr_clr) cr <= 1'b0;
      else if (wr)     cr <= wdata[B_CR];
   end

   assign word = {keep_q[2], keep_q[1], ifsel, keep_q[0], chi, dhi, endian,
                  {RSV_W{1'b0}}, cr, en};
endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
   import dma_chain_pkg::*;
#(
   parameter int unsigned LO_W = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            cr,
   input  logic            cur_wr,
   input  logic [LO_W-1:0] cur_wdata,
   input  logic            fetch_done,
   input  logic [LO_W-1:0] fetch_next,
   input  logic            xfer_done,
   output logic            fetch_req,
   output logic            xfer_run,
   output logic            active,
   output logic            cr_clr,
   output logic [LO_W-1:0] cur_q,
   output logic [LO_W-1:0] nxt_q
);
   chain_state_e st_q, st_d;
   logic reread_q, reread_d;
   logic [LO_W-1:0] cur_d, nxt_d;
   logic nxt_zero;

   assign nxt_zero = (nxt_q == '0);

   always_comb begin
      st_d     = st_q;
      reread_d = reread_q;
      cur_d    = cur_q;
      nxt_d    = nxt_q;
      cr_clr   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (cur_wr) cur_d = cur_wdata;
            if (en && cr) begin
               st_d     = ST_FETCH;
               reread_d = 1'b1;
            end
         end
         ST_FETCH: begin
            if (en && fetch_done) begin
               nxt_d  = fetch_next;
               cr_clr = reread_q;
               st_d   = ST_XFER;
            end
         end
         ST_XFER: begin
            if (en && xfer_done) begin
               if (!nxt_zero) begin
                  cur_d    = nxt_q;
                  cr_clr   = 1'b1;
                  reread_d = 1'b0;
                  st_d     = ST_FETCH;
               end else if (cr) begin
                  reread_d = 1'b1;
                  st_d     = ST_FETCH;
               end else begin
                  st_d = ST_IDLE;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         reread_q <= 1'b0;
         cur_q    <= '0;
         nxt_q    <= '0;
      end else begin
         st_q     <= st_d;
         reread_q <= reread_d;
         cur_q    <= cur_d;
         nxt_q    <= nxt_d;
      end
   end

   assign fetch_req = en && (st_q == ST_FETCH);
   assign xfer_run  = en && (st_q == ST_XFER);
   assign active    = (st_q != ST_IDLE);
endmodule

// File: rtl/dma_chain_ctl.sv
module dma_chain_ctl
   import dma_chain_pkg::*;
#(
   parameter int unsigned ADDR_LO_W = 32,
   parameter bit          RDATA_REG = 1'b0,
   localparam int unsigned FA_W     = ADDR_LO_W + HI_W
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strap_if_sel,
   input  logic                 reg_wr,
   input  logic [1:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic                 fetch_req,
   output logic [FA_W-1:0]      fetch_addr,
   input  logic                 fetch_done,
   input  logic [ADDR_LO_W-1:0] fetch_next,
   output logic                 xfer_run,
   input  logic                 xfer_done,
   output logic                 active,
   output logic                 endian_sel,
   output logic                 if_sel,
   output logic [HI_W-1:0]      crc_addr_hi
);
   generate
      if (ADDR_LO_W > 32 || ADDR_LO_W < 8) begin : g_bad_width
         $error("ADDR_LO_W must lie in 8..32");
      end
   endgenerate

   logic [31:0]          ctl_word;
   logic                 en_q, cr_q, cr_clr;
   logic [HI_W-1:0]      dhi;
   logic [ADDR_LO_W-1:0] cur_q, nxt_q;
   logic [31:0]          rd_mux;

   dma_ctl_regs i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .strap  (strap_if_sel),
      .wr     (reg_wr && reg_addr == RA_CTL),
      .wdata  (reg_wdata),
      .cr_clr (cr_clr),
      .word   (ctl_word),
      .en     (en_q),
      .cr     (cr_q),
      .endian (endian_sel),
      .ifsel  (if_sel),
      .dhi    (dhi),
      .chi    (crc_addr_hi)
   );

   dma_chain_fsm #(.LO_W(ADDR_LO_W)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en_q),
      .cr         (cr_q),
      .cur_wr     (reg_wr && reg_addr == RA_CUR),
      .cur_wdata  (reg_wdata[ADDR_LO_W-1:0]),
      .fetch_done (fetch_done),
      .fetch_next (fetch_next),
      .xfer_done  (xfer_done),
      .fetch_req  (fetch_req),
      .xfer_run   (xfer_run),
      .active     (active),
      .cr_clr     (cr_clr),
      .cur_q      (cur_q),
      .nxt_q      (nxt_q)
   );

   assign fetch_addr = {dhi, cur_q};

   always_comb begin
      rd_mux = '0;
      unique case (reg_addr)
         RA_CTL:  rd_mux = ctl_word;
         RA_CUR:  rd_mux[ADDR_LO_W-1:0] = cur_q;
         RA_NXT:  rd_mux[ADDR_LO_W-1:0] = nxt_q;
         default: rd_mux = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         logic [31:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign reg_rdata = rd_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
   parameter int unsigned LO_W = 32
)(
   input logic            clk,
   input logic            rst_n,
   input logic            en_q,
   input logic            cr_q,
   input logic [LO_W-1:0] nxt_q,
   input logic            fetch_req,
   input logic            fetch_done,
   input logic            xfer_run,
   input logic            xfer_done,
   input logic            active
);
   p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (!fetch_req && !xfer_run));

   p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && $past(!en_q)) |-> $stable(active));

   p_idle_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> $past(xfer_done));

   p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_run && xfer_done && nxt_q != '0) |=> (fetch_req && !cr_q));

   p_run_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_done) |=> (xfer_run || !en_q));

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && en_q && cr_q) |=> (fetch_req || !en_q));
endmodule

bind dma_chain_ctl dma_chain_chk #(.LO_W(ADDR_LO_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_q       (en_q),
   .cr_q       (cr_q),
   .nxt_q      (nxt_q),
   .fetch_req  (fetch_req),
   .fetch_done (fetch_done),
   .xfer_run   (xfer_run),
   .xfer_done  (xfer_done),
   .active     (active)
);

// File: tb/test_dma_chain_ctl.sv
module test_dma_chain_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_if_sel = 1'b1;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fetch_req;
   logic [35:0] fetch_addr;
   logic        fetch_done = 1'b0;
   logic [31:0] fetch_next = '0;
   logic        xfer_run;
   logic        xfer_done = 1'b0;
   logic        active;
   logic        endian_sel;
   logic        if_sel;
   logic [3:0]  crc_addr_hi;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   dma_chain_ctl i_dma_chain_ctl (
      .clk(clk), .rst_n(rst_n), .strap_if_sel(strap_if_sel),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_done(fetch_done), .fetch_next(fetch_next), .xfer_run(xfer_run),
      .xfer_done(xfer_done), .active(active), .endian_sel(endian_sel),
      .if_sel(if_sel), .crc_addr_hi(crc_addr_hi)
   );

   // control word with preserved bits set, CRC field A, endian 1, if_sel 0
   function automatic logic [31:0] ctlw(logic [3:0] dhi, logic en, logic cr);
      return 32'hDA08_0000 | (32'(dhi) << 20) | (32'(cr) << 1) | 32'(en);
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic fdone(logic [31:0] nxt);
      fetch_done = 1'b1; fetch_next = nxt;
      @(negedge clk);
      fetch_done = 1'b0;
   endtask

   task automatic xdone();
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [31:0] cda;
      logic [31:0] nxt;
      logic [3:0]  dhi;
      int          len;
      void'($urandom(32'd2718));

      repeat (3) cyc();
      rd(2'd0, r);
      chk("R1 ctl reset", r, 32'h2000_0000);
      chk("R1 active/req/run reset", {active, fetch_req, xfer_run}, 3'b000);
      rst_n = 1'b1;
      cyc();

      // R2 start with enable and resume in one write
      wr(2'd1, 32'h1000_0040);
      wr(2'd0, ctlw(4'h5, 1'b1, 1'b1) | 32'h0007_FFFC);
      chk("R2 no fetch on write edge", fetch_req, 1'b0);
      cyc();
      chk("R2 fetch next clock", fetch_req, 1'b1);
      chk("R2 fetch address", fetch_addr, 36'h5_1000_0040);
      rd(2'd0, r);
      chk("R9 readback reserved zero", r, 32'hDA58_0003);
      chk("R9 side outputs", {if_sel, endian_sel, crc_addr_hi}, 6'b01_1010);

      // R3 re-read loads next address and clears resume
      fdone(32'h1000_0080);
      chk("R3 xfer_run", xfer_run, 1'b1);
      rd(2'd2, r);
      chk("R3 next addr", r, 32'h1000_0080);
      rd(2'd0, r);
      chk("R3 resume cleared", r[1], 1'b0);

      // R7 suspend and resume
      wr(2'd0, ctlw(4'h5, 1'b0, 1'b0));
      chk("R7 suspended outputs", {fetch_req, xfer_run, active}, 3'b001);
      repeat (4) cyc();
      chk("R7 still suspended", {fetch_req, xfer_run, active}, 3'b001);
      wr(2'd0, ctlw(4'h5, 1'b1, 1'b0));
      chk("R7 resume without refetch", {fetch_req, xfer_run}, 2'b01);

      // R11 window change while active, R10 address write ignored
      wr(2'd0, ctlw(4'h6, 1'b1, 1'b0));
      wr(2'd1, 32'hDEAD_0000);
      rd(2'd1, r);
      chk("R10 cur addr unchanged while active", r, 32'h1000_0040);

      // R4 advance
      xdone();
      chk("R4 fetch next desc", {fetch_req, fetch_addr}, {1'b1, 36'h6_1000_0080});
      chk("R11 new window used", fetch_addr[35:32], 4'h6);
      rd(2'd1, r);
      chk("R4 cur addr updated", r, 32'h1000_0080);

      // R5 chain end with resume set re-reads
      fdone(32'h0);
      wr(2'd0, ctlw(4'h6, 1'b1, 1'b1));
      xdone();
      chk("R5 re-read same desc", {fetch_req, fetch_addr}, {1'b1, 36'h6_1000_0080});
      fdone(32'h0);
      rd(2'd0, r);
      chk("R3 resume cleared after re-read", r[1], 1'b0);

      // R6 chain end goes idle
      xdone();
      chk("R6 idle", {active, fetch_req, xfer_run}, 3'b000);
      rd(2'd1, r);
      chk("R6 cur addr kept", r, 32'h1000_0080);

      // R8 resume set with enable clear
      wr(2'd0, ctlw(4'h6, 1'b0, 1'b1));
      repeat (3) cyc();
      chk("R8 no start while disabled", {active, fetch_req}, 2'b00);
      wr(2'd0, ctlw(4'h6, 1'b1, 1'b1));
      cyc();
      chk("R8 start once enabled", fetch_req, 1'b1);
      fdone(32'h0);
      xdone();
      chk("R6 idle again", active, 1'b0);

      // random chains
      for (int c = 0; c < 25; c++) begin
         dhi = 4'($urandom);
         cda = $urandom | 32'h4;
         wr(2'd1, cda);
         rd(2'd1, r);
         chk("R10 cur addr write while idle", r, cda);
         wr(2'd0, ctlw(dhi, 1'b1, 1'b1));
         cyc();
         chk("R2 random start", {fetch_req, fetch_addr}, {1'b1, dhi, cda});
         len = 1 + int'($urandom % 4);
         for (int i = 0; i < len; i++) begin
            nxt = (i == len - 1) ? 32'h0 : ($urandom | 32'h1);
            fdone(nxt);
            chk("R3 random run", xfer_run, 1'b1);
            if ($urandom % 3 == 0) begin
               wr(2'd0, ctlw(dhi, 1'b0, 1'b0));
               repeat (1 + int'($urandom % 5)) cyc();
               chk("R7 random suspend", {xfer_run, active}, 2'b01);
               wr(2'd0, ctlw(dhi, 1'b1, 1'b0));
               chk("R7 random resume", {fetch_req, xfer_run}, 2'b01);
            end
            xdone();
            if (nxt != 32'h0) begin
               chk("R4 random advance", {fetch_req, fetch_addr}, {1'b1, dhi, nxt});
            end else begin
               chk("R6 random end", active, 1'b0);
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule